// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Channel

This block is one channel of a bus-master DMA controller that sits beside a disk interface. Software programs three registers: a command byte, a status byte and a 32-bit pointer to a table of descriptors in memory. It loads the table pointer, clears the two sticky status flags, picks the direction and then writes the start bit. The channel then walks the table one descriptor at a time. Each descriptor names a physical buffer and a byte count. The channel moves that buffer as 32-bit words between a device-side FIFO handshake and a simple request/acknowledge memory port.

Each descriptor occupies two little-endian words. Word 0 is the buffer base address. In word 1, bits 15:0 are the byte count, bits 30:16 are reserved and bit 31 flags the final entry. A count of zero stands for 64 KiB. A count that is not a multiple of four is rounded up to whole words. When the final entry is used up, the channel drops its active flag and raises its interrupt flag. A memory error response raises the error flag and halts the channel. Clearing the start bit halts it at the next word boundary. The device's own interrupt line also sets the interrupt flag. Both flags are cleared by writing one to them.

Top module: `bm_dma_channel`

## Requirements
- R1: Registers are selected by byte offset: command at 0 (bit 0 start, bit 3 direction, other bits read 0), status at 2, table pointer at 4. The pointer stores bits 31:2 and its bits 1:0 read 0. After reset, all three registers read 0, and no memory or device request is made.
- R2: Writing the command byte with bit 0 = 1 while the channel is inactive sets status bit 0 (active) from the next cycle. The channel then fetches the first descriptor from the table pointer.
- R3: Descriptor word 0 gives the buffer address, and its bits 1:0 are ignored. Word 1 bits 15:0 give the byte count, bit 31 marks the last entry, and bits 30:16 are ignored. The next descriptor lies 8 bytes further on, wrapping inside the same 4 KiB page. The memory port holds its request and address stable until it is acknowledged.
- R4: A descriptor moves ceil(count/4) words, and a count of 0 moves 16384 words (64 KiB).
- R5: With direction bit 3 = 1, words popped from the device FIFO are written to memory. With bit 3 = 0, words read from memory are handed to the device. In both cases the words move in order, at buffer addresses rising by 4.
- R6: Once the last descriptor's words are done, status bit 0 clears, status bit 2 (interrupt) sets, and no further memory request is made.
- R7: Writing command bit 0 = 0 while the channel is active halts it at a word boundary. Status bit 0 clears, bit 2 stays clear, and every word taken from the source is delivered to the destination.
- R8: A write to command bit 3 while the channel is active has no effect. Bit 3 reads back unchanged, and the running transfer keeps its direction.
- R9: An error response on the memory port sets status bit 1 (error) and clears status bit 0. The channel issues no further request, and status bit 2 stays clear.
- R10: While the device interrupt input is 1, status bit 2 is set.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. Status bits 5 and 6 (drive 0 and drive 1 DMA-capable) are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid with mem_ack |
| dev_rx_valid | input | 1 | Device has a word for memory |
| dev_rx_data | input | 32 | Word from the device |
| dev_rx_ready | output | 1 | Channel takes the device word |
| dev_tx_valid | output | 1 | Channel offers a word to the device |
| dev_tx_data | output | 32 | Word to the device |
| dev_tx_ready | input | 1 | Device accepts the word |
| dev_irq | input | 1 | Device interrupt line |

## Verification
Descriptor chains of one to three entries are driven in both directions, with random buffer placement, random counts and random FIFO back-pressure on either side. Data order is compared word by word, which separates correct address stepping, correct descriptor sequencing and correct direction choice. Directed cases cover the following:
- unaligned counts, which tell ceil rounding from truncation;
- a zero count, which must move exactly 16384 words;
- reserved and low address bits set in a descriptor;
- a mid-run stop, where source and destination word counts must agree;
- a mid-run flip of the direction bit;
- an error response;
- the device interrupt line;
- the write-one-to-clear rules.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;

    parameter int ADDR_W  = 32;
    parameter int DATA_W  = 32;
    parameter int CNT_W   = 16;
    parameter int PAGE_W  = 12;
    parameter int DESC_BYTES = 8;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WCNT_W = CNT_W - $clog2(WORD_BYTES) + 1;

    localparam logic [2:0] OFS_CMD = 3'd0;
    localparam logic [2:0] OFS_STS = 3'd2;
    localparam logic [2:0] OFS_PTR = 3'd4;

    typedef struct packed {
        logic       rsv7;
        logic       cap1;
        logic       cap0;
        logic [1:0] rsv43;
        logic       irq;
        logic       err;
        logic       act;
    } bm_status_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [WCNT_W-1:0] words;
        logic              last;
    } bm_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_WORD,
        ST_MEM_RD,
        ST_DEV_TX,
        ST_DEV_RX,
        ST_MEM_WR
    } bm_state_t;

    function automatic logic [WCNT_W-1:0] word_count(input logic [CNT_W-1:0] cnt);
        logic [CNT_W:0] padded;
        if (cnt == '0) begin
            word_count = WCNT_W'((CNT_W + 1)'(1) << (CNT_W - $clog2(WORD_BYTES)));
        end else begin
            padded = (CNT_W + 1)'(cnt) + (CNT_W + 1)'(WORD_BYTES - 1);
            word_count = WCNT_W'(padded >> $clog2(WORD_BYTES));
        end
    endfunction

    function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a,
                                                    input int unsigned step);
        logic [PAGE_W-1:0] low;
        low = a[PAGE_W-1:0] + PAGE_W'(step);
        page_step = {a[ADDR_W-1:PAGE_W], low};
    endfunction

endpackage

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
    import bm_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              fault,
    input  logic              dev_irq,
    output logic              go,
    output logic              halt,
    output logic              dir,
    output logic [ADDR_W-1:0] tbl_ptr
);

    logic              cmd_start;
    logic              cmd_dir;
    logic [ADDR_W-1:0] ptr_q;
    logic              err_q;
    logic              irq_q;
    logic [1:0]        cap_q;
    bm_status_t        sts;

    logic wr_cmd, wr_sts, wr_ptr;
    assign wr_cmd = reg_wr && (reg_addr == OFS_CMD);
    assign wr_sts = reg_wr && (reg_addr == OFS_STS);
    assign wr_ptr = reg_wr && (reg_addr == OFS_PTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_start <= 1'b0;
            cmd_dir   <= 1'b0;
            ptr_q     <= '0;
            err_q     <= 1'b0;
            irq_q     <= 1'b0;
            cap_q     <= '0;
        end else begin
            if (wr_cmd) begin
                cmd_start <= reg_wdata[0];
                if (!busy) cmd_dir <= reg_wdata[3];
            end
            if (wr_ptr) ptr_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
            if (wr_sts) cap_q <= reg_wdata[6:5];
            err_q <= (err_q && !(wr_sts && reg_wdata[1])) || fault;
            irq_q <= (irq_q && !(wr_sts && reg_wdata[2])) || fin || dev_irq;
        end
    end

    assign go      = wr_cmd && reg_wdata[0] && !busy;
    assign halt    = !cmd_start;
    assign dir     = cmd_dir;
    assign tbl_ptr = ptr_q;

    always_comb begin
        sts       = '0;
        sts.act   = busy;
        sts.err   = err_q;
        sts.irq   = irq_q;
        sts.cap0  = cap_q[0];
        sts.cap1  = cap_q[1];
        case (reg_addr)
            OFS_CMD: reg_rdata = {24'd0, 4'd0, cmd_dir, 2'b00, cmd_start};
            OFS_STS: reg_rdata = {24'd0, sts};
            OFS_PTR: reg_rdata = 32'(ptr_q);
            default: reg_rdata = '0;
        endcase
    end

    // R6: completion of the last descriptor raises the interrupt flag
    p_fin_irq_r6: assert property (@(posedge clk) disable iff (rst) fin |=> irq_q);
    // R9: an error response raises the error flag
    p_fault_err_r9: assert property (@(posedge clk) disable iff (rst) fault |=> err_q);
    // R8: direction is frozen while the engine runs
    p_dir_hold_r8: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(cmd_dir));
    // R10: device interrupt line sets the flag
    p_dev_irq_r10: assert property (@(posedge clk) disable iff (rst) dev_irq |=> irq_q);
    // R11: writing zero to the error bit keeps it
    p_w1c_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(wr_sts && reg_wdata[1])) |=> err_q);

endmodule

// File: rtl/bm_dma_engine.sv
module bm_dma_engine
    import bm_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              halt,
    input  logic              dir_in,
    input  logic [ADDR_W-1:0] tbl_ptr,
    output logic              busy,
    output logic              fin,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [DATA_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready
);

    bm_state_t         state;
    bm_desc_t          desc;
    logic [ADDR_W-1:0] dptr;
    logic [DATA_W-1:0] hold;
    logic              dir_q;
    logic              done_desc;

    assign done_desc = (desc.words == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            desc  <= '0;
            dptr  <= '0;
            hold  <= '0;
            dir_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    dptr  <= tbl_ptr;
                    dir_q <= dir_in;
                    state <= ST_FETCH_LO;
                end
                ST_FETCH_LO: if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        desc.base <= {mem_rdata[ADDR_W-1:2], 2'b00};
                        state     <= ST_FETCH_HI;
                    end
                end
                ST_FETCH_HI: if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        desc.words <= word_count(mem_rdata[CNT_W-1:0]);
                        desc.last  <= mem_rdata[DATA_W-1];
                        dptr       <= page_step(dptr, DESC_BYTES);
                        state      <= ST_WORD;
                    end
                end
                ST_WORD: begin
                    if (done_desc && desc.last) state <= ST_IDLE;
                    else if (halt)              state <= ST_IDLE;
                    else if (done_desc)         state <= ST_FETCH_LO;
                    else if (dir_q)             state <= ST_DEV_RX;
                    else                        state <= ST_MEM_RD;
                end
                ST_MEM_RD: if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        hold  <= mem_rdata;
                        state <= ST_DEV_TX;
                    end
                end
                ST_DEV_TX: if (dev_tx_ready) begin
                    desc.words <= desc.words - 1'b1;
                    desc.base  <= desc.base + ADDR_W'(WORD_BYTES);
                    state      <= ST_WORD;
                end
                ST_DEV_RX: begin
                    if (dev_rx_valid) begin
                        hold  <= dev_rx_data;
                        state <= ST_MEM_WR;
                    end else if (halt) begin
                        state <= ST_IDLE;
                    end
                end
                ST_MEM_WR: if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        desc.words <= desc.words - 1'b1;
                        desc.base  <= desc.base + ADDR_W'(WORD_BYTES);
                        state      <= ST_WORD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req = (state == ST_FETCH_LO) || (state == ST_FETCH_HI) ||
                  (state == ST_MEM_RD)   || (state == ST_MEM_WR);
        mem_we  = (state == ST_MEM_WR);
        case (state)
            ST_FETCH_LO: mem_addr = dptr;
            ST_FETCH_HI: mem_addr = page_step(dptr, WORD_BYTES);
            default:     mem_addr = desc.base;
        endcase
    end

    assign mem_wdata    = hold;
    assign dev_tx_valid = (state == ST_DEV_TX);
    assign dev_tx_data  = hold;
    assign dev_rx_ready = (state == ST_DEV_RX);
    assign busy         = (state != ST_IDLE);
    assign fin          = (state == ST_WORD) && done_desc && desc.last;
    assign fault        = mem_req && mem_ack && mem_err;

    // R3: a pending memory request keeps its request and address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R4: a word is never moved against an exhausted count
    p_words_live_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_tx_valid || (mem_req && mem_we)) |-> !done_desc);
    // R6: after completion no request follows
    p_fin_quiet_r6: assert property (@(posedge clk) disable iff (rst) fin |=> !mem_req);
    // R9: after an error response no request follows
    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (rst) fault |=> !mem_req);

endmodule

// File: rtl/bm_dma_channel.sv
module bm_dma_channel
    import bm_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic        dev_rx_valid,
    input  logic [31:0] dev_rx_data,
    output logic        dev_rx_ready,
    output logic        dev_tx_valid,
    output logic [31:0] dev_tx_data,
    input  logic        dev_tx_ready,
    input  logic        dev_irq
);

    logic              busy, fin, fault, go, halt, dir;
    logic [ADDR_W-1:0] tbl_ptr;

    bm_dma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .fin       (fin),
        .fault     (fault),
        .dev_irq   (dev_irq),
        .go        (go),
        .halt      (halt),
        .dir       (dir),
        .tbl_ptr   (tbl_ptr)
    );

    bm_dma_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .go           (go),
        .halt         (halt),
        .dir_in       (dir),
        .tbl_ptr      (tbl_ptr),
        .busy         (busy),
        .fin          (fin),
        .fault        (fault),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_data  (dev_rx_data),
        .dev_rx_ready (dev_rx_ready),
        .dev_tx_valid (dev_tx_valid),
        .dev_tx_data  (dev_tx_data),
        .dev_tx_ready (dev_tx_ready)
    );

endmodule

// File: tb/bm_dma_channel_bench.sv
`timescale 1ns/1ps
module bm_dma_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack, mem_err;
    logic        dev_rx_valid;
    logic [31:0] dev_rx_data;
    logic        dev_rx_ready, dev_tx_valid;
    logic [31:0] dev_tx_data;
    logic        dev_tx_ready;
    logic        dev_irq = 1'b0;

    always #2.5 clk = ~clk;

    bm_dma_channel u_bm_dma_channel (.*);

    // memory model and device models
    logic [31:0] mem [0:4095];
    logic        host_we = 1'b0;
    logic [11:0] host_idx = '0;
    logic [31:0] host_data = '0;
    logic        err_en = 1'b0;
    logic [31:0] err_base = 32'h3000;
    logic        rx_gate, tx_gate;
    int          rx_sel = 1;
    int          tx_sel = 1;
    int          rx_n, tx_n, wr_n;
    logic [31:0] tx_log [0:255];

    int checks = 0;
    int failures = 0;

    function automatic logic [31:0] init_pat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] rx_pat(input int n);
        return 32'hC0DE0000 + 32'(n) * 32'h00010003;
    endfunction

    function automatic int words_of(input int cnt);
        if (cnt == 0) return 16384;
        return (cnt + 3) / 4;
    endfunction

    assign dev_rx_valid = rx_gate;
    assign dev_rx_data  = rx_pat(rx_n);
    assign dev_tx_ready = tx_gate;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) mem[i] <= init_pat(i);
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            mem_rdata <= '0;
            rx_n <= 0; tx_n <= 0; wr_n <= 0;
            rx_gate <= 1'b0; tx_gate <= 1'b0;
        end else begin
            if (host_we) mem[host_idx] <= host_data;
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_err   <= err_en && (mem_addr >= err_base) && (mem_addr < err_base + 32'h100);
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wr_n <= wr_n + 1;
                end
            end
            if (dev_rx_valid && dev_rx_ready) rx_n <= rx_n + 1;
            if (dev_tx_valid && dev_tx_ready) begin
                tx_log[tx_n % 256] <= dev_tx_data;
                tx_n <= tx_n + 1;
            end
            rx_gate <= ($urandom % 4) < 4'(rx_sel) + 1;
            tx_gate <= ($urandom % 4) < 4'(tx_sel) + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_idx = addr[13:2]; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_desc(input logic [31:0] tb, input int k, input logic [31:0] a,
                            input int cnt, input bit last);
        poke(tb + 32'(8 * k), a);
        poke(tb + 32'(8 * k + 4), {last, 7'h2A, 8'hFF, 16'(cnt)});
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] s;
        ok = 1'b0;
        for (int i = 0; i < 120000; i++) begin
            rd(3'd2, s);
            if (!s[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic launch(input logic [31:0] tb, input bit dir);
        wr(3'd4, tb);
        wr(3'd2, 32'h06);
        wr(3'd0, {28'd0, dir, 3'b000});
        wr(3'd0, {28'd0, dir, 3'b001});
    endtask

    logic [31:0] d_addr [0:3];
    int          d_cnt  [0:3];

    task automatic verify(input int nd, input bit dir, input int tx0, input int rx0, input string req);
        int k = 0;
        for (int j = 0; j < nd; j++) begin
            for (int w = 0; w < words_of(d_cnt[j]); w++) begin
                logic [31:0] a = {d_addr[j][31:2], 2'b00} + 32'(4 * w);
                if (dir) check(mem[a[13:2]] == rx_pat(rx0 + k), req, mem[a[13:2]], rx_pat(rx0 + k));
                else     check(tx_log[(tx0 + k) % 256] == mem[a[13:2]], req, tx_log[(tx0 + k) % 256], mem[a[13:2]]);
                k++;
            end
        end
        if (dir) check(rx_n - rx0 == k, "R4 word total", 32'(rx_n - rx0), 32'(k));
        else     check(tx_n - tx0 == k, "R4 word total", 32'(tx_n - tx0), 32'(k));
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        bit ok;
        int tx0, rx0, wr0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check(v == 32'h0, "R1 cmd reset", v, 32'h0);
        rd(3'd2, v); check(v == 32'h0, "R1 status reset", v, 32'h0);
        rd(3'd4, v); check(v == 32'h0, "R1 pointer reset", v, 32'h0);
        check(!mem_req && !dev_tx_valid && !dev_rx_ready, "R1 quiet after reset", {29'd0, mem_req, dev_tx_valid, dev_rx_ready}, 32'h0);
        wr(3'd4, 32'h0000_1237); rd(3'd4, v);
        check(v == 32'h0000_1234, "R1 pointer alignment", v, 32'h0000_1234);
        wr(3'd0, 32'hF6); rd(3'd0, v);
        check(v == 32'h0, "R1 cmd unused bits", v, 32'h0);

        // R11 capability bits and write-one-to-clear
        wr(3'd2, 32'h60); rd(3'd2, v);
        check(v == 32'h60, "R11 capability bits", v, 32'h60);
        @(negedge clk); dev_irq = 1'b1; @(negedge clk); dev_irq = 1'b0;
        rd(3'd2, v); check(v[2] == 1'b1, "R10 device interrupt", v, 32'h64);
        wr(3'd2, 32'h60); rd(3'd2, v);
        check(v == 32'h64, "R11 zero write keeps interrupt", v, 32'h64);
        wr(3'd2, 32'h04); rd(3'd2, v);
        check(v == 32'h00, "R11 one clears interrupt", v, 32'h00);

        // R3 R4 R5 directed: reserved bits, unaligned address bits, odd counts
        d_addr[0] = 32'h2003; d_cnt[0] = 6;
        d_addr[1] = 32'h2402; d_cnt[1] = 13;
        set_desc(32'h0100, 0, d_addr[0], d_cnt[0], 1'b0);
        set_desc(32'h0100, 1, d_addr[1], d_cnt[1], 1'b1);
        tx0 = tx_n;
        launch(32'h0100, 1'b0);
        rd(3'd2, v); check(v[0] == 1'b1, "R2 active after start", v, 32'h1);
        wait_idle(ok);
        check(ok, "R6 completes", {31'd0, ok}, 32'h1);
        rd(3'd2, v); check(v[2:0] == 3'b100, "R6 interrupt set and inactive", v, 32'h4);
        verify(2, 1'b0, tx0, 0, "R5 memory to device data");

        // R3 page wrap: table at last entry of a page wraps to page start
        d_addr[0] = 32'h2800; d_cnt[0] = 8;
        d_addr[1] = 32'h2900; d_cnt[1] = 4;
        set_desc(32'h0FF8, 0, d_addr[0], d_cnt[0], 1'b0);
        set_desc(32'h0000, 0, d_addr[1], d_cnt[1], 1'b1);
        rx0 = rx_n;
        launch(32'h0FF8, 1'b1);
        wait_idle(ok);
        verify(2, 1'b1, 0, rx0, "R3 descriptor walk with page wrap");

        // randomized chains
        for (int it = 0; it < 8; it++) begin
            int nd = 1 + int'($urandom % 3);
            bit dir = 1'($urandom % 2);
            rx_sel = int'($urandom % 4);
            tx_sel = int'($urandom % 4);
            for (int j = 0; j < nd; j++) begin
                int wn = 1 + int'($urandom % 8);
                d_addr[j] = 32'h2000 + 32'(j * 32'h400) + 32'(($urandom % 32) * 4);
                d_cnt[j]  = wn * 4 - int'($urandom % 4);
                set_desc(32'h0200, j, d_addr[j], d_cnt[j], j == nd - 1);
            end
            tx0 = tx_n; rx0 = rx_n;
            launch(32'h0200, dir);
            wait_idle(ok);
            check(ok, "R6 random completes", {31'd0, ok}, 32'h1);
            rd(3'd2, v); check(v[2:0] == 3'b100, "R6 random status", v, 32'h4);
            verify(nd, dir, tx0, rx0, "R5 random data order");
        end
        rx_sel = 1; tx_sel = 1;

        // R8 direction write ignored while active
        d_addr[0] = 32'h2000; d_cnt[0] = 128;
        set_desc(32'h0300, 0, d_addr[0], d_cnt[0], 1'b1);
        tx0 = tx_n; rx0 = rx_n;
        launch(32'h0300, 1'b0);
        repeat (20) @(negedge clk);
        wr(3'd0, 32'h09);
        rd(3'd0, v); check(v[3] == 1'b0, "R8 direction bit unchanged", v, 32'h1);
        wait_idle(ok);
        check(rx_n == rx0, "R8 no device pops", 32'(rx_n - rx0), 32'h0);
        verify(1, 1'b0, tx0, 0, "R8 transfer keeps direction");

        // R7 stop mid-transfer, device to memory
        d_addr[0] = 32'h3400; d_cnt[0] = 256;
        set_desc(32'h0300, 0, d_addr[0], d_cnt[0], 1'b1);
        rx0 = rx_n; wr0 = wr_n;
        launch(32'h0300, 1'b1);
        repeat (60) @(negedge clk);
        wr(3'd0, 32'h08);
        wait_idle(ok);
        check(ok, "R7 stops", {31'd0, ok}, 32'h1);
        repeat (4) @(negedge clk);
        check((rx_n - rx0) == (wr_n - wr0), "R7 words popped equal words written", 32'(wr_n - wr0), 32'(rx_n - rx0));
        check((rx_n - rx0) > 0 && (rx_n - rx0) < 64, "R7 stopped early", 32'(rx_n - rx0), 32'd32);
        rd(3'd2, v); check(v[2:0] == 3'b000, "R7 no interrupt on stop", v, 32'h0);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req || dev_rx_ready) ok = 1'b0;
        end
        check(ok, "R7 quiet after stop", {31'd0, ok}, 32'h1);

        // R9 error response
        err_en = 1'b1;
        set_desc(32'h0300, 0, 32'h3000, 16, 1'b1);
        tx0 = tx_n;
        launch(32'h0300, 1'b0);
        wait_idle(ok);
        rd(3'd2, v); check(v[2:0] == 3'b010, "R9 error set, inactive, no interrupt", v, 32'h2);
        check(tx_n == tx0, "R9 no data delivered", 32'(tx_n - tx0), 32'h0);
        wr(3'd2, 32'h04); rd(3'd2, v);
        check(v[1] == 1'b1, "R11 error kept by other bit", v, 32'h2);
        wr(3'd2, 32'h02); rd(3'd2, v);
        check(v[1] == 1'b0, "R11 error cleared", v, 32'h0);
        err_en = 1'b0;

        // R4 zero count moves 64 KiB
        rx_sel = 3; tx_sel = 3;
        set_desc(32'h0300, 0, 32'h2000, 0, 1'b1);
        tx0 = tx_n;
        launch(32'h0300, 1'b0);
        wait_idle(ok);
        check(tx_n - tx0 == 16384, "R4 zero count word total", 32'(tx_n - tx0), 32'd16384);
        rd(3'd2, v); check(v[2:0] == 3'b100, "R6 after 64 KiB", v, 32'h4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule